// File: doc/BRIEF.md
# Programmable CIC Decimator with Output Scaling

This block is a cascaded integrator-comb decimation filter for signed samples. Each sample that arrives with its valid strobe passes through a chain of integrators running at the input rate. One integrated value out of every D is handed to an equal number of comb stages running at the output rate. Both the filter order and the decimation ratio are set by configuration inputs.

The integrator and comb registers are 26 bits wide and wrap modulo 2^26. The comb result is larger than the 24-bit output word, so a scale stage always follows it. That stage is an arithmetic right shift with round-half-up. Any scaled value that does not fit in 24 signed bits is clamped, and the clamp raises a sticky saturation flag. A typical setting is order 5 with a ratio of 4 or 5 and 14-bit input. At a ratio of 4 the gain is 1024 and a zero shift fits. At a ratio of 5 a shift of 2 brings a full-scale signal back into range.

Configuration is meant to be changed only while reset is held.

Top module: `cic_decim`

## Requirements
- R1: While `rst` is high on a clock edge, all filter state and the decimation count are cleared. After that edge, `out_valid`, `out_data` and `sat_flag` read 0. The first output appears in the cycle after the D-th valid input that follows reset.
- R2: An input is taken only on edges where `in_valid` is high. On other cycles `in_data` has no effect on any later output, and `out_valid` stays low in the next cycle.
- R3: Exactly one output is produced for every D valid inputs. `out_valid` is high for one cycle, directly after the edge that takes the D-th input. D is `cfg_ratio` (4 bits, 1 to 15), and a code of 0 acts as 1.
- R4: On each valid input, integrator stage k adds the new output of stage k-1 (stage 0 adds the sign-extended input) and stores the sum. On each output, comb stage k subtracts its stored value from its input, passes on the difference and stores its input. All of this arithmetic wraps modulo 2^26.
- R5: `cfg_order` (3 bits) selects how many integrator and comb stages are active. Codes 1 to 5 are taken as given, 0 acts as 1, and 6 or 7 act as 5. Inactive stages pass their input through unchanged.
- R6: The comb result v is scaled as (v + 2^(s-1)) >> s (arithmetic), or left as v when s = 0. The shift s is `cfg_shift` (2 bits, 0 to 2), and a code of 3 acts as 2.
- R7: A scaled result above +8388607 is output as +8388607, and one below -8388608 is output as -8388608. Either clamp sets `sat_flag` in the same cycle that the output appears. `sat_flag` is never set except by a clamped output.
- R8: `sat_flag` stays set until an edge with `sat_clr` high clears it. If a clamped output and `sat_clr` meet on the same edge, the flag remains set.
- R9: With order 5, a 14-bit input and D = 4 or D = 5, a constant input x settles to an output equal to x·D^5, scaled as in R6, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_order | input | 3 | Number of active stages |
| cfg_ratio | input | 4 | Decimation ratio D |
| cfg_shift | input | 2 | Right shift applied by the scale stage |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 14 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 24 | Signed scaled output sample |
| sat_flag | output | 1 | Sticky saturation indication |

## Verification
The hardest situations to reach from the ports are two cases that random stimulus seldom produces for long.

The first is a comb result that exceeds 24 bits while still fitting in 26 bits, so that the clamp must act rather than the wrap. The bench reaches it by holding the input at the positive rail for many decimation periods at order 5 and ratio 5 with no shift. It then does the same at the negative rail, so the filter settles at a gain of 3125 and pushes both clamp limits.

The second is integrator wrap-around. A full sweep over order, ratio and shift drives the full 14-bit input range, with gaps in the valid strobe. The larger ratios therefore overflow the 26-bit integrators, and every output is compared with a bench model that wraps in the same way.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // limit a configuration code to an inclusive range
  function automatic int unsigned clip(int unsigned code, int unsigned lo, int unsigned hi);
    if (code < lo) return lo;
    if (code > hi) return hi;
    return code;
  endfunction
endpackage

// File: rtl/cic_integrators.sv
module cic_integrators #(
  parameter int IN_W   = 14,
  parameter int ACC_W  = 26,
  parameter int STAGES = 5,
  parameter int ORD_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ORD_W-1:0]        order,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] link [STAGES+1];

  assign link[0] = {{(ACC_W-IN_W){din[IN_W-1]}}, din};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sum;
    logic                    live;
    assign live        = ORD_W'(g) < order;
    assign sum         = acc + link[g];
    assign link[g+1]   = live ? sum : link[g];
    always_ff @(posedge clk) begin
      if (rst)              acc <= '0;
      else if (en && live)  acc <= sum;
    end
  end

  assign dout = link[STAGES];
endmodule

// File: rtl/cic_combs.sv
module cic_combs #(
  parameter int ACC_W  = 26,
  parameter int STAGES = 5,
  parameter int ORD_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ORD_W-1:0]        order,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] link [STAGES+1];

  assign link[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic signed [ACC_W-1:0] dly;
    logic signed [ACC_W-1:0] diff;
    logic                    live;
    assign live      = ORD_W'(g) < order;
    assign diff      = link[g] - dly;
    assign link[g+1] = live ? diff : link[g];
    always_ff @(posedge clk) begin
      if (rst)              dly <= '0;
      else if (en && live)  dly <= link[g];
    end
  end

  assign dout = link[STAGES];
endmodule

// File: rtl/cic_scale.sv
module cic_scale #(
  parameter int ACC_W = 26,
  parameter int OUT_W = 24,
  parameter int SH_W  = 2
) (
  input  logic signed [ACC_W-1:0] din,
  input  logic [SH_W-1:0]         shift,
  output logic signed [OUT_W-1:0] dout,
  output logic                    ovf
);
  localparam int WW = ACC_W + 1;
  localparam logic signed [WW-1:0] HI = WW'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [WW-1:0] LO = -HI - WW'(1);

  logic signed [WW-1:0] ext;
  logic signed [WW-1:0] rnd;
  logic signed [WW-1:0] wide;
  logic signed [WW-1:0] shifted;

  always_comb begin
    ext     = {din[ACC_W-1], din};
    rnd     = (WW'(1) << shift) >>> 1;
    wide    = ext + rnd;
    shifted = wide >>> shift;
    ovf     = 1'b0;
    if (shifted > HI) begin
      dout = HI[OUT_W-1:0];
      ovf  = 1'b1;
    end else if (shifted < LO) begin
      dout = LO[OUT_W-1:0];
      ovf  = 1'b1;
    end else begin
      dout = shifted[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
#(
  parameter int IN_W      = 14,
  parameter int ACC_W     = 26,
  parameter int OUT_W     = 24,
  parameter int MAX_ORDER = 5,
  parameter int CNT_W     = 4,
  parameter int SH_W      = 2,
  parameter int MAX_SHIFT = 2,
  localparam int ORD_W    = $clog2(MAX_ORDER + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ORD_W-1:0]        cfg_order,
  input  logic [CNT_W-1:0]        cfg_ratio,
  input  logic [SH_W-1:0]         cfg_shift,
  input  logic                    sat_clr,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data,
  output logic                    sat_flag
);
  logic [ORD_W-1:0]        ord_eff;
  logic [CNT_W-1:0]        rat_eff;
  logic [SH_W-1:0]         sh_eff;
  logic [CNT_W-1:0]        cnt;
  logic                    dump;
  logic signed [ACC_W-1:0] integ;
  logic signed [ACC_W-1:0] comb;
  logic signed [OUT_W-1:0] scaled;
  logic                    ovf;

  assign ord_eff = ORD_W'(clip(int'(cfg_order), 1, MAX_ORDER));
  assign rat_eff = CNT_W'(clip(int'(cfg_ratio), 1, (1 << CNT_W) - 1));
  assign sh_eff  = SH_W'(clip(int'(cfg_shift), 0, MAX_SHIFT));
  assign dump    = in_valid && (cnt == rat_eff - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (dump)     cnt <= '0;
    else if (in_valid) cnt <= cnt + CNT_W'(1);
  end

  cic_integrators #(.IN_W(IN_W), .ACC_W(ACC_W), .STAGES(MAX_ORDER), .ORD_W(ORD_W)) u_int (
    .clk(clk), .rst(rst), .en(in_valid), .order(ord_eff), .din(in_data), .dout(integ)
  );

  cic_combs #(.ACC_W(ACC_W), .STAGES(MAX_ORDER), .ORD_W(ORD_W)) u_comb (
    .clk(clk), .rst(rst), .en(dump), .order(ord_eff), .din(integ), .dout(comb)
  );

  cic_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_scale (
    .din(comb), .shift(sh_eff), .dout(scaled), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= dump;
      if (dump) out_data <= scaled;
      if (dump && ovf)  sat_flag <= 1'b1;
      else if (sat_clr) sat_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic             sat_flag,
  input logic             sat_clr,
  input logic [CNT_W-1:0] cfg_ratio
);
  logic [CNT_W-1:0] seen;
  logic [CNT_W-1:0] rat;

  assign rat = (cfg_ratio == '0) ? CNT_W'(1) : cfg_ratio;

  always_ff @(posedge clk) begin
    if (rst)           seen <= '0;
    else if (in_valid) seen <= (seen == rat - CNT_W'(1)) ? '0 : seen + CNT_W'(1);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> (!out_valid && !sat_flag));

  assert_gated_input_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_valid_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && ($past(seen) == $past(rat) - CNT_W'(1))));

  assert_sat_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_flag) |-> out_valid);

  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sat_clr) |=> sat_flag);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (sat_clr && !in_valid) |=> !sat_flag);
endmodule

bind cic_decim cic_decim_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .sat_flag(sat_flag), .sat_clr(sat_clr), .cfg_ratio(cfg_ratio)
);

// File: tb/cic_decim_test.sv
module cic_decim_test;
  localparam int CYC = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [2:0]         cfg_order = 3'd5;
  logic [3:0]         cfg_ratio = 4'd4;
  logic [1:0]         cfg_shift = 2'd0;
  logic               sat_clr = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [13:0] in_data = '0;
  logic               out_valid;
  logic signed [23:0] out_data;
  logic               sat_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  cic_decim uut (
    .clk(clk), .rst(rst), .cfg_order(cfg_order), .cfg_ratio(cfg_ratio),
    .cfg_shift(cfg_shift), .sat_clr(sat_clr), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .sat_flag(sat_flag)
  );

  // bench model state
  logic signed [25:0] m_int  [5];
  logic signed [25:0] m_comb [5];
  int      m_cnt;
  bit      m_sat;
  int      ord_e, rat_e, sh_e;
  longint  last_out;
  bit      last_valid;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic lfsr_next();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic model_reset();
    for (int k = 0; k < 5; k++) begin
      m_int[k]  = '0;
      m_comb[k] = '0;
    end
    m_cnt = 0;
    m_sat = 0;
  endtask

  task automatic model_eval(input logic signed [13:0] x, output bit emit,
                            output longint y, output bit ovf);
    logic signed [25:0] v;
    logic signed [25:0] old;
    longint lv;
    v = 26'(x);
    for (int k = 0; k < ord_e; k++) begin
      m_int[k] = m_int[k] + v;
      v = m_int[k];
    end
    emit = 0; y = 0; ovf = 0;
    m_cnt++;
    if (m_cnt >= rat_e) begin
      m_cnt = 0;
      emit = 1;
      for (int k = 0; k < ord_e; k++) begin
        old = m_comb[k];
        m_comb[k] = v;
        v = v - old;
      end
      lv = longint'(v);
      if (sh_e > 0) lv = (lv + (64'sd1 <<< (sh_e - 1))) >>> sh_e;
      if (lv > 8388607)       begin lv = 8388607;  ovf = 1; end
      else if (lv < -8388608) begin lv = -8388608; ovf = 1; end
      y = lv;
    end
  endtask

  task automatic configure(int o, int r, int s);
    cfg_order = 3'(o); cfg_ratio = 4'(r); cfg_shift = 2'(s);
    ord_e = (o == 0) ? 1 : (o > 5 ? 5 : o);
    rat_e = (r == 0) ? 1 : r;
    sh_e  = (s > 2) ? 2 : s;
    in_valid = 0; sat_clr = 0; rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    model_reset();
    // R1: state right after reset
    check(out_valid == 0, "R1 out_valid after reset", longint'(out_valid), 0);
    check(out_data == 0, "R1 out_data after reset", longint'(out_data), 0);
    check(sat_flag == 0, "R1 sat_flag after reset", longint'(sat_flag), 0);
  endtask

  task automatic step(bit v, logic signed [13:0] x, bit clr, string tag);
    bit emit, ovf;
    longint y;
    emit = 0; ovf = 0; y = 0;
    in_valid = v; in_data = x; sat_clr = clr;
    if (v) model_eval(x, emit, y, ovf);
    if (emit && ovf) m_sat = 1;
    else if (clr)    m_sat = 0;
    @(negedge clk);
    check(out_valid == emit, "R3 out_valid timing", longint'(out_valid), longint'(emit));
    if (emit) check(longint'(out_data) == y, tag, longint'(out_data), y);
    check(sat_flag == m_sat, "R8 sat_flag state", longint'(sat_flag), longint'(m_sat));
    last_valid = out_valid;
    if (out_valid) last_out = longint'(out_data);
    in_valid = 0; sat_clr = 0;
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int ratios [6] = '{1, 2, 3, 4, 5, 7};
    longint expv;

    // R1: first output exactly after D valid inputs
    configure(5, 5, 0);
    for (int i = 0; i < 4; i++) step(1, 14'sd100, 0, "R1 early data");
    check(last_valid == 0, "R1 no output before D inputs", longint'(last_valid), 0);
    step(1, 14'sd100, 0, "R1 first output value");
    check(last_valid == 1, "R1 output after D inputs", longint'(last_valid), 1);

    // R4/R5/R6 sweep over order, ratio and shift with gapped valid
    for (int o = 0; o < 8; o++)
      for (int ri = 0; ri < 6; ri++)
        for (int s = 0; s < 4; s++) begin
          if ((o == 0 || o > 5) && s != 0) continue;
          configure(o, ratios[ri], s);
          for (int i = 0; i < 24; i++) begin
            lfsr_next();
            step(lfsr[15] | lfsr[3], 14'(lfsr[13:0]), 0, "R4/R5/R6 sweep output");
          end
        end

    // R3: ratio code 0 acts as 1
    configure(2, 0, 0);
    for (int i = 0; i < 10; i++) begin
      lfsr_next();
      step(1, 14'(lfsr[13:0]), 0, "R3 ratio zero output");
    end

    // R2: invalid cycles carry garbage that must not matter
    configure(3, 4, 0);
    for (int i = 0; i < 60; i++) begin
      lfsr_next();
      step(i % 3 == 0, 14'(lfsr[13:0]), 0, "R2 gapped input output");
    end

    // R9: DC gain, order 5 ratio 4, no shift
    configure(5, 4, 0);
    for (int i = 0; i < 40; i++) step(1, 14'sd8191, 0, "R9 dc d4");
    check(last_out == 64'sd8191 * 1024, "R9 dc gain d4", last_out, 64'sd8191 * 1024);

    // R9: DC gain, order 5 ratio 5, shift 2
    configure(5, 5, 2);
    for (int i = 0; i < 50; i++) step(1, 14'sd8191, 0, "R9 dc d5");
    expv = (64'sd8191 * 3125 + 2) >>> 2;
    check(last_out == expv, "R9 dc gain d5 shift2", last_out, expv);
    check(sat_flag == 0, "R9 no saturation d5 shift2", longint'(sat_flag), 0);

    // R7: full-scale sine at order 5 ratio 4 never saturates
    configure(5, 4, 0);
    for (int i = 0; i < 512; i++)
      step(1, 14'($rtoi($floor(8191.0 * $sin(6.283185307179586 * i / 64.0) + 0.5))), 0,
           "R7 sine output");
    check(sat_flag == 0, "R7 sine no saturation", longint'(sat_flag), 0);

    // R7: offset full-scale input at ratio 5 without shift must clamp high
    configure(5, 5, 0);
    for (int i = 0; i < 50; i++) step(1, 14'sd8191, 0, "R7 positive clamp output");
    check(last_out == 8388607, "R7 positive clamp value", last_out, 8388607);
    check(sat_flag == 1, "R7 flag on clamp", longint'(sat_flag), 1);

    // R8: clear while saturating output continues: set wins
    for (int i = 0; i < 10; i++) step(1, 14'sd8191, 1, "R8 clear vs set");
    // R8: clear with no output
    step(0, 14'sd0, 1, "R8 clear idle");
    check(sat_flag == 0, "R8 flag cleared", longint'(sat_flag), 0);

    // R7: negative rail clamps low; R8: flag stays while later outputs are in range
    for (int i = 0; i < 60; i++) step(1, -14'sd8192, 0, "R7 negative clamp output");
    check(last_out == -8388608, "R7 negative clamp value", last_out, -8388608);
    for (int i = 0; i < 60; i++) step(1, 14'sd0, 0, "R8 sticky zero output");
    check(last_out == 0, "R8 settled output", last_out, 0);
    check(sat_flag == 1, "R8 flag sticky", longint'(sat_flag), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule